// File: doc/BRIEF.md
# Integer Arithmetic Unit with Multiply/Divide Result Registers

This block is the integer execution unit of a small 32-bit load/store processor core. In the same cycle it computes additions, subtractions, bitwise logic, shifts and set-on-less-than comparisons from two register operands and a 5-bit shift field, and reports signed overflow as a plain flag. No trap is raised.

Multiplication and division run through a single iterative engine. The engine takes one bit per cycle and writes its 64-bit outcome into two dedicated result registers, called HI and LO. The core reads these registers back with two move operations. While the engine is running, a move or a further multiply/divide request holds the stall output high. The pipeline control freezes on this output until the engine is idle again.

Top module: `arith_unit`

## Requirements
- R1: Codes 0 (signed add), 1 (unsigned add), 2 (signed subtract) and 3 (unsigned subtract) return opa+opb or opa-opb modulo 2^32. `ovf_o` is 1 only for codes 0 and 2, and only when the true signed result lies outside [-2^31, 2^31-1]. For every other code `ovf_o` is 0.
- R2: Codes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of opa and opb.
- R3: Codes 10, 11 and 12 shift opb left, right logically and right arithmetically by `shamt_i`. Codes 13, 14 and 15 do the same shifts by opa[4:0]. The logical right shift fills with zeros and the arithmetic right shift fills with opb[31].
- R4: Code 8 (signed) and code 9 (unsigned) return 1 in bit 0 when opa < opb and 0 otherwise. Bits 31..1 are always 0.
- R5: Code 16 (signed multiply) and code 17 (unsigned multiply) leave bits 63..32 of the product in HI and bits 31..0 in LO.
- R6: Code 18 (signed divide) and code 19 (unsigned divide) leave the quotient in LO and the remainder in HI. The quotient truncates toward zero and the remainder takes the dividend's sign. The signed case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A divide with opb = 0 gives LO = 0xFFFFFFFF and HI = opa, for both the signed and the unsigned code.
- R8: A multiply/divide code with `valid_i` high while idle starts the engine at that clock edge. `busy_o` then reads 1 for exactly 32 cycles, and HI/LO change only at the edge that ends the run. A multiply/divide request while busy is ignored.
- R9: Code 20 returns HI and code 21 returns LO on `result_o`. `stall_o` is 1 while `busy_o` is 1 and `valid_i` carries a code from 16 to 21.
- R10: After reset, HI and LO read 0 and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation is being issued this cycle |
| op_i | input | 5 | Operation code |
| opa_i | input | 32 | First operand (rs) |
| opb_i | input | 32 | Second operand (rt), also shifted value |
| shamt_i | input | 5 | Shift count from the instruction field |
| result_o | output | 32 | Combinational result |
| ovf_o | output | 1 | Signed add/subtract overflow |
| busy_o | output | 1 | Multiply/divide engine running |
| stall_o | output | 1 | Issued operation must be held |

## Verification
Some behaviours hold on every cycle and are checked by assertions:
- the overflow flag appears only with the signed add and subtract codes;
- the comparison results never set a bit above bit 0;
- a stall is never raised while the engine is idle;
- a running engine counts on without restarting and drops busy right after its final step;
- HI and LO hold their values except at that final step.

The arithmetic values can only be shown by the bench scenarios, which compare results against computed products and quotients:
- signed and unsigned products and quotients;
- remainder signs;
- the divide-by-zero and most-negative-over-minus-one corners;
- the fill used by arithmetic shifts;
- the exact 32-cycle busy window;
- a request issued in the middle of a run being dropped.

// File: rtl/arith_pkg.sv
package arith_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOR   = 5'd7,
        OP_SLT   = 5'd8,
        OP_SLTU  = 5'd9,
        OP_SLL   = 5'd10,
        OP_SRL   = 5'd11,
        OP_SRA   = 5'd12,
        OP_SLLV  = 5'd13,
        OP_SRLV  = 5'd14,
        OP_SRAV  = 5'd15,
        OP_MULT  = 5'd16,
        OP_MULTU = 5'd17,
        OP_DIV   = 5'd18,
        OP_DIVU  = 5'd19,
        OP_MFHI  = 5'd20,
        OP_MFLO  = 5'd21
    } alu_op_e;

    function automatic logic op_is_muldiv(alu_op_e op);
        return (op == OP_MULT) || (op == OP_MULTU) || (op == OP_DIV) || (op == OP_DIVU);
    endfunction

    function automatic logic op_is_move(alu_op_e op);
        return (op == OP_MFHI) || (op == OP_MFLO);
    endfunction

endpackage

// File: rtl/arith_shift.sv
module arith_shift #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  res_o
);
    // A left shift is done by bit-reversing, shifting right with zero fill,
    // and reversing back, so only one right-shifting array is needed.
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] src;
    logic [W-1:0] stg [0:SW];
    logic         fill;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = data_i[W-1-i];
        assign rev_out[i] = stg[SW][W-1-i];
    end

    assign src    = left_i ? rev_in : data_i;
    assign fill   = arith_i & ~left_i & data_i[W-1];
    assign stg[0] = src;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stg[s+1] = amt_i[s] ? {{SH{fill}}, stg[s][W-1:SH]} : stg[s];
    end

    assign res_o = left_i ? rev_out : stg[SW];

endmodule

// File: rtl/arith_logic.sv
module arith_logic
    import arith_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  alu_op_e       op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [SW-1:0] shamt_i,
    output logic [W-1:0]  res_o,
    output logic          ovf_o
);
    logic [W-1:0]  sum;
    logic [W-1:0]  dif;
    logic [W-1:0]  shres;
    logic [SW-1:0] amt;
    logic          var_shift;
    logic          left;
    logic          arith;
    logic          lt_s;
    logic          lt_u;

    assign sum       = a_i + b_i;
    assign dif       = a_i - b_i;
    assign lt_s      = $signed(a_i) < $signed(b_i);
    assign lt_u      = a_i < b_i;
    assign var_shift = (op_i == OP_SLLV) || (op_i == OP_SRLV) || (op_i == OP_SRAV);
    assign left      = (op_i == OP_SLL)  || (op_i == OP_SLLV);
    assign arith     = (op_i == OP_SRA)  || (op_i == OP_SRAV);
    assign amt       = var_shift ? a_i[SW-1:0] : shamt_i;

    arith_shift #(.W(W)) u_shift (
        .data_i  (b_i),
        .amt_i   (amt),
        .left_i  (left),
        .arith_i (arith),
        .res_o   (shres)
    );

    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                res_o = sum;
                ovf_o = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
            end
            OP_ADDU: res_o = sum;
            OP_SUB: begin
                res_o = dif;
                ovf_o = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
            end
            OP_SUBU: res_o = dif;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOR:  res_o = ~(a_i | b_i);
            OP_SLT:  res_o = {{(W-1){1'b0}}, lt_s};
            OP_SLTU: res_o = {{(W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: res_o = shres;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/arith_muldiv.sv
module arith_muldiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         div_i,
    input  logic         signed_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          neg_lo;
        logic          neg_hi;
        logic          dz;
        logic [W-1:0]  wh;
        logic [W-1:0]  wl;
        logic [W-1:0]  mc;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } md_state_t;

    md_state_t q, d;

    logic          sa, sb;
    logic [W-1:0]  mag_a, mag_b;
    logic [W:0]    psum;
    logic [W-1:0]  mul_h, mul_l;
    logic [W:0]    shf;
    logic          ge;
    logic [W-1:0]  sub;
    logic [W-1:0]  div_h, div_l;
    logic [2*W-1:0] prod, prod_s;
    logic [W-1:0]  quo, rem;

    always_comb begin
        sa    = signed_i & a_i[W-1];
        sb    = signed_i & b_i[W-1];
        mag_a = sa ? (~a_i + 1'b1) : a_i;
        mag_b = sb ? (~b_i + 1'b1) : b_i;

        // one shift-add multiply step
        psum  = q.wl[0] ? ({1'b0, q.wh} + {1'b0, q.mc}) : {1'b0, q.wh};
        mul_h = psum[W:1];
        mul_l = {psum[0], q.wl[W-1:1]};

        // one restoring divide step
        shf   = {q.wh, q.wl[W-1]};
        ge    = shf >= {1'b0, q.mc};
        sub   = shf[W-1:0] - q.mc;
        div_h = ge ? sub : shf[W-1:0];
        div_l = {q.wl[W-2:0], ge};

        prod   = {mul_h, mul_l};
        prod_s = q.neg_lo ? (~prod + 1'b1) : prod;
        quo    = q.dz ? '1 : (q.neg_lo ? (~div_l + 1'b1) : div_l);
        rem    = q.neg_hi ? (~div_h + 1'b1) : div_h;

        d = q;
        if (!q.busy) begin
            if (start_i) begin
                d.busy   = 1'b1;
                d.cnt    = '0;
                d.is_div = div_i;
                d.wh     = '0;
                d.dz     = div_i && (b_i == '0);
                if (div_i) begin
                    d.wl     = mag_a;
                    d.mc     = mag_b;
                    d.neg_lo = sa ^ sb;
                    d.neg_hi = sa;
                end else begin
                    d.wl     = mag_b;
                    d.mc     = mag_a;
                    d.neg_lo = sa ^ sb;
                    d.neg_hi = 1'b0;
                end
            end
        end else begin
            d.wh  = q.is_div ? div_h : mul_h;
            d.wl  = q.is_div ? div_l : mul_l;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                if (q.is_div) begin
                    d.hi = rem;
                    d.lo = quo;
                end else begin
                    d.hi = prod_s[2*W-1:W];
                    d.lo = prod_s[W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign hi_o   = q.hi;
    assign lo_o   = q.lo;

    // R8: a run in progress advances its step counter and is not restarted
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != LAST) |=> (q.busy && q.cnt == $past(q.cnt) + 1'b1));

    // R8: the run ends right after its final step
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt == LAST) |=> !q.busy);

    // R8: HI/LO are untouched during a run except at its last edge
    assert_hilo_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != LAST) |=> ($stable(q.hi) && $stable(q.lo)));

    // R8: HI/LO are untouched while idle with no request
    assert_hilo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !start_i) |=> ($stable(q.hi) && $stable(q.lo) && !q.busy));

endmodule

// File: rtl/arith_unit.sv
module arith_unit
    import arith_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [SW-1:0] shamt_i,
    output logic [W-1:0]  result_o,
    output logic          ovf_o,
    output logic          busy_o,
    output logic          stall_o
);
    alu_op_e      op;
    logic [W-1:0] alu_res;
    logic         alu_ovf;
    logic [W-1:0] hi, lo;
    logic         is_md, is_mv, start;

    assign op    = alu_op_e'(op_i);
    assign is_md = op_is_muldiv(op);
    assign is_mv = op_is_move(op);
    assign start = valid_i && is_md && !busy_o;

    arith_logic #(.W(W)) u_logic (
        .op_i    (op),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .shamt_i (shamt_i),
        .res_o   (alu_res),
        .ovf_o   (alu_ovf)
    );

    arith_muldiv #(.W(W)) u_muldiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .div_i    ((op == OP_DIV) || (op == OP_DIVU)),
        .signed_i ((op == OP_MULT) || (op == OP_DIV)),
        .a_i      (opa_i),
        .b_i      (opb_i),
        .busy_o   (busy_o),
        .hi_o     (hi),
        .lo_o     (lo)
    );

    always_comb begin
        if (op == OP_MFHI)      result_o = hi;
        else if (op == OP_MFLO) result_o = lo;
        else                    result_o = alu_res;
    end

    assign ovf_o   = alu_ovf;
    assign stall_o = valid_i && busy_o && (is_md || is_mv);

    // R1: overflow only for the signed add and subtract codes
    assert_ovf_signed_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (op == OP_ADD || op == OP_SUB));

    // R4: comparison results occupy bit 0 only
    assert_slt_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SLT || op == OP_SLTU) |-> (result_o[W-1:1] == '0));

    // R9: a stall only happens while the engine runs
    assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> busy_o);

endmodule

// File: tb/arith_unit_bench.sv
module arith_unit_bench;
    import arith_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = 5'd0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        ovf_o, busy_o, stall_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    arith_unit u_arith_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .shamt_i(shamt_i),
        .result_o(result_o), .ovf_o(ovf_o), .busy_o(busy_o), .stall_o(stall_o)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [32:0] exp_alu(logic [4:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        logic [31:0] r = '0;
        logic o = 1'b0;
        logic [4:0] va = a[4:0];
        case (op)
            5'd0: begin t = sa + sb; r = t[31:0]; o = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
            5'd1: r = a + b;
            5'd2: begin t = sa - sb; r = t[31:0]; o = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
            5'd3: r = a - b;
            5'd4: r = a & b;
            5'd5: r = a | b;
            5'd6: r = a ^ b;
            5'd7: r = ~(a | b);
            5'd8: r = {31'b0, sa < sb};
            5'd9: r = {31'b0, a < b};
            5'd10: r = b << sh;
            5'd11: r = b >> sh;
            5'd12: r = $unsigned($signed(b) >>> sh);
            5'd13: r = b << va;
            5'd14: r = b >> va;
            5'd15: r = $unsigned($signed(b) >>> va);
            default: r = '0;
        endcase
        return {o, r};
    endfunction

    function automatic logic [63:0] exp_md(logic [4:0] op, logic [31:0] a, logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint q, r;
        logic [63:0] p;
        case (op)
            5'd16: begin p = sa * sb; return p; end
            5'd17: begin p = {32'b0, a} * {32'b0, b}; return p; end
            5'd18: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                q = sa / sb; r = sa % sb;
                return {r[31:0], q[31:0]};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    function automatic string alu_req(logic [4:0] op);
        if (op <= 5'd3) return "R1";
        if (op <= 5'd7) return "R2";
        if (op <= 5'd9) return "R4";
        return "R3";
    endfunction

    function automatic string md_req(logic [4:0] op, logic [31:0] b);
        if (op <= 5'd17) return "R5";
        if (b == 0) return "R7";
        return "R6";
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'($urandom_range(0, 40));
            default: return $urandom;
        endcase
    endfunction

    task automatic run_alu(logic [4:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
        logic [32:0] e;
        @(negedge clk);
        valid_i = 1'b1; op_i = op; opa_i = a; opb_i = b; shamt_i = sh;
        #1;
        e = exp_alu(op, a, b, sh);
        chk(alu_req(op), {32'b0, result_o}, {32'b0, e[31:0]});
        chk("R1 ovf", {63'b0, ovf_o}, {63'b0, e[32]});
        valid_i = 1'b0;
    endtask

    task automatic run_md(logic [4:0] op, logic [31:0] a, logic [31:0] b, bit inject);
        logic [63:0] e = exp_md(op, a, b);
        int cyc = 0;
        @(negedge clk);
        valid_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        op_i = 5'd21; opa_i = ~a; opb_i = b + 32'd3;
        #1;
        chk("R8 busy", {63'b0, busy_o}, 64'd1);
        chk("R9 stall", {63'b0, stall_o}, 64'd1);
        while (busy_o && cyc < 100) begin
            cyc++;
            if (inject && cyc == 5) op_i = 5'd17;
            if (inject && cyc == 6) op_i = 5'd21;
            @(negedge clk);
            #1;
        end
        chk("R8 cycles", 64'(cyc), 64'd32);
        chk("R9 stall release", {63'b0, stall_o}, 64'd0);
        chk({md_req(op, b), " lo"}, {32'b0, result_o}, {32'b0, e[31:0]});
        op_i = 5'd20;
        #1;
        chk({md_req(op, b), " hi"}, {32'b0, result_o}, {32'b0, e[63:32]});
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        op_i = 5'd20; #1;
        chk("R10 hi", {32'b0, result_o}, 64'd0);
        op_i = 5'd21; #1;
        chk("R10 lo", {32'b0, result_o}, 64'd0);
        chk("R10 busy", {63'b0, busy_o}, 64'd0);

        // directed corners
        run_alu(5'd0, 32'h7FFF_FFFF, 32'h1, 5'd0);          // R1 signed overflow
        run_alu(5'd1, 32'h7FFF_FFFF, 32'h1, 5'd0);          // R1 unsigned no flag
        run_alu(5'd2, 32'h8000_0000, 32'h1, 5'd0);          // R1 subtract overflow
        run_alu(5'd3, 32'h0, 32'h1, 5'd0);                  // R1 wraps
        run_alu(5'd7, 32'h0F0F_0000, 32'h0000_00FF, 5'd0);  // R2 NOR
        run_alu(5'd12, 32'h0, 32'h8000_0000, 5'd31);        // R3 arithmetic fill
        run_alu(5'd11, 32'h0, 32'h8000_0000, 5'd31);        // R3 zero fill
        run_alu(5'd14, 32'hFFFF_FFE5, 32'hF000_0000, 5'd0); // R3 count from opa[4:0]
        run_alu(5'd13, 32'h0000_0021, 32'h0000_0001, 5'd7); // R3 variable ignores shamt
        run_alu(5'd8, 32'hFFFF_FFFF, 32'h1, 5'd0);          // R4 signed
        run_alu(5'd9, 32'hFFFF_FFFF, 32'h1, 5'd0);          // R4 unsigned

        run_md(5'd16, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0);  // R5 signed product
        run_md(5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R5 unsigned product
        run_md(5'd18, 32'hFFFF_FFF9, 32'h2, 1'b0);          // R6 -7/2
        run_md(5'd18, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R6 min / -1
        run_md(5'd18, 32'hFFFF_FF00, 32'h0, 1'b0);          // R7 signed
        run_md(5'd19, 32'h1234_5678, 32'h0, 1'b0);          // R7 unsigned
        run_md(5'd19, 32'd1000, 32'd7, 1'b1);               // R8 request while busy ignored

        // random mix
        for (int i = 0; i < 300; i++) begin
            run_alu(5'($urandom_range(0, 15)), pick_val(), pick_val(), 5'($urandom_range(0, 31)));
        end
        for (int i = 0; i < 60; i++) begin
            run_md(5'($urandom_range(16, 19)), pick_val(), pick_val(), (i % 7) == 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule